// File: doc/BRIEF.md
# Multiplexed Parallel I/O Controller

This block sits between a bank of bidirectional pads and one on-chip peripheral. Each pad line is owned either by the peripheral or by the controller itself. A peripheral-owned line carries the peripheral's output value and output enable to the pad. A controller-owned line acts as a general-purpose parallel I/O. Its direction and output value come from controller registers.

Software reaches the block over a single-cycle register bus with valid, write, address and data signals. Ownership, direction and output data each use a pair of write-one registers: one register sets bits and the other clears them. Each pair has a read-only status word. The pad input value always passes straight through to the peripheral. A two-stage synchronised copy of it can be read by software at any time, whoever owns the line.

Top module: `pio_mux_ctrl`

## Requirements
- R1: After reset, every line is controller-owned (ownership status all ones), every line is an input (direction status all zeros, `pad_oe` all zeros) and the output data word is zero.
- R2: A write to offset 0 (ownership set) gives each line whose data bit is 1 to the controller; lines whose bit is 0 keep their owner.
- R3: A write to offset 1 (ownership clear) gives each line whose data bit is 1 to the peripheral; lines whose bit is 0 keep their owner.
- R4: A read of offset 2 returns the ownership status, with 1 meaning controller and 0 meaning peripheral; a write to offset 2 changes nothing.
- R5: Writes of ones to offset 3 make lines outputs, writes of ones to offset 4 make them inputs, zero bits leave the direction alone, and a read of offset 5 returns the direction (1 = output).
- R6: On a controller-owned line, `pad_oe` equals the direction bit and `pad_out` equals the output data bit.
- R7: On a peripheral-owned line, `pad_oe` and `pad_out` follow `per_oe` and `per_out`; the controller direction and data settings have no effect on it.
- R8: Writes of ones to offset 6 set output data bits, writes of ones to offset 7 clear them, and a read of offset 8 returns the output data word.
- R9: `per_in` equals `pad_in` combinationally, and a read of offset 9 returns `pad_in` as it stood two clock edges before the read is captured, regardless of ownership.
- R10: Read data appears on `bus_rdata` the cycle after the read request; reads of the write-only offsets 0, 1, 3, 4, 6 and 7, and of unused offsets, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Bus request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data, registered |
| per_out | input | NPIN | Peripheral output values |
| per_oe | input | NPIN | Peripheral output enables |
| per_in | output | NPIN | Pad values passed to the peripheral |
| pad_in | input | NPIN | Pad input values |
| pad_out | output | NPIN | Pad output values |
| pad_oe | output | NPIN | Pad output enables |

## Verification
The hardest case to reach is a line whose controller direction and data bits were set while it was owned by the peripheral, and which is then handed back. The stimulus first gives some lines to the peripheral. It then writes direction ones over those same lines and changes `per_oe` under them. The bench checks that the pad follows only the peripheral. After that, ownership set writes that touch a subset of bits show the stored direction taking over on exactly those lines.

// File: rtl/pio_pkg.sv
package pio_pkg;

   localparam int OFS_OWN_SET  = 0;
   localparam int OFS_OWN_CLR  = 1;
   localparam int OFS_OWN_STAT = 2;
   localparam int OFS_DIR_SET  = 3;
   localparam int OFS_DIR_CLR  = 4;
   localparam int OFS_DIR_STAT = 5;
   localparam int OFS_DAT_SET  = 6;
   localparam int OFS_DAT_CLR  = 7;
   localparam int OFS_DAT_STAT = 8;
   localparam int OFS_PIN_STAT = 9;

   localparam int MIN_ADDR_W = 4;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_WRITE = 2'd1,
      SRC_READ  = 2'd2
   } bus_kind_e;

endpackage

// File: rtl/pio_setclr_reg.sv
module pio_setclr_reg #(
   parameter int         W        = 8,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter bit         CLR_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_bits,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] q
);

   logic [W-1:0] q_nxt;

   generate
      if (W < 1) begin : g_bad_w
         $error("pio_setclr_reg: W must be at least 1");
      end
      if (CLR_WINS) begin : g_clr_wins
         always_comb q_nxt = (q | set_bits) & ~clr_bits;
      end else begin : g_set_wins
         always_comb q_nxt = (q & ~clr_bits) | set_bits;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= q_nxt;
   end

   AST_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_bits != '0) && (clr_bits == '0)) |=> ((q & $past(set_bits)) == $past(set_bits))) else $error("set bits not applied"); // R2
   AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_bits != '0) && (set_bits == '0)) |=> ((q & $past(clr_bits)) == '0)) else $error("clear bits not applied"); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_bits == '0) && (clr_bits == '0)) |=> $stable(q)) else $error("state moved without write"); // R2

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pio_in_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   assign q = stage[STAGES-1];

endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
   parameter int NPIN = 8
) (
   input  logic [NPIN-1:0] own_ctl,
   input  logic [NPIN-1:0] ctl_dir,
   input  logic [NPIN-1:0] ctl_dat,
   input  logic [NPIN-1:0] per_out,
   input  logic [NPIN-1:0] per_oe,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe
);

   generate
      for (genvar p = 0; p < NPIN; p++) begin : g_pin
         always_comb begin
            if (own_ctl[p]) begin
               pad_oe[p]  = ctl_dir[p];
               pad_out[p] = ctl_dat[p];
            end else begin
               pad_oe[p]  = per_oe[p];
               pad_out[p] = per_out[p];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pio_mux_ctrl.sv
module pio_mux_ctrl
   import pio_pkg::*;
#(
   parameter int NPIN        = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit CLR_WINS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_vld,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NPIN-1:0]   bus_wdata,
   output logic [NPIN-1:0]   bus_rdata,
   input  logic [NPIN-1:0]   per_out,
   input  logic [NPIN-1:0]   per_oe,
   output logic [NPIN-1:0]   per_in,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe
);

   localparam logic [NPIN-1:0] ALL_ONES = {NPIN{1'b1}};
   localparam logic [NPIN-1:0] ALL_ZERO = '0;

   generate
      if (NPIN < 1 || NPIN > 32) begin : g_bad_npin
         $error("pio_mux_ctrl: NPIN must be 1..32");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_aw
         $error("pio_mux_ctrl: ADDR_W too small for register map");
      end
   endgenerate

   bus_kind_e kind;
   always_comb begin
      if (!bus_vld)    kind = SRC_NONE;
      else if (bus_wr) kind = SRC_WRITE;
      else             kind = SRC_READ;
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic [NPIN-1:0] own_set, own_clr, dir_set, dir_clr, dat_set, dat_clr;
   always_comb begin
      own_set = '0; own_clr = '0;
      dir_set = '0; dir_clr = '0;
      dat_set = '0; dat_clr = '0;
      if (kind == SRC_WRITE) begin
         if (hit(bus_addr, OFS_OWN_SET)) own_set = bus_wdata;
         if (hit(bus_addr, OFS_OWN_CLR)) own_clr = bus_wdata;
         if (hit(bus_addr, OFS_DIR_SET)) dir_set = bus_wdata;
         if (hit(bus_addr, OFS_DIR_CLR)) dir_clr = bus_wdata;
         if (hit(bus_addr, OFS_DAT_SET)) dat_set = bus_wdata;
         if (hit(bus_addr, OFS_DAT_CLR)) dat_clr = bus_wdata;
      end
   end

   logic [NPIN-1:0] own_q, dir_q, dat_q, pin_q;

   pio_setclr_reg #(.W(NPIN), .RST_VAL(ALL_ONES), .CLR_WINS(CLR_WINS)) u_own (
      .clk(clk), .rst_n(rst_n), .set_bits(own_set), .clr_bits(own_clr), .q(own_q));

   pio_setclr_reg #(.W(NPIN), .RST_VAL(ALL_ZERO), .CLR_WINS(CLR_WINS)) u_dir (
      .clk(clk), .rst_n(rst_n), .set_bits(dir_set), .clr_bits(dir_clr), .q(dir_q));

   pio_setclr_reg #(.W(NPIN), .RST_VAL(ALL_ZERO), .CLR_WINS(CLR_WINS)) u_dat (
      .clk(clk), .rst_n(rst_n), .set_bits(dat_set), .clr_bits(dat_clr), .q(dat_q));

   pio_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_q));

   pio_pad_mux #(.NPIN(NPIN)) u_mux (
      .own_ctl(own_q), .ctl_dir(dir_q), .ctl_dat(dat_q),
      .per_out(per_out), .per_oe(per_oe),
      .pad_out(pad_out), .pad_oe(pad_oe));

   assign per_in = pad_in;

   logic [NPIN-1:0] rd_sel;
   always_comb begin
      rd_sel = '0;
      if (hit(bus_addr, OFS_OWN_STAT)) rd_sel = own_q;
      if (hit(bus_addr, OFS_DIR_STAT)) rd_sel = dir_q;
      if (hit(bus_addr, OFS_DAT_STAT)) rd_sel = dat_q;
      if (hit(bus_addr, OFS_PIN_STAT)) rd_sel = pin_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bus_rdata <= '0;
      else if (kind == SRC_READ) bus_rdata <= rd_sel;
   end

   // checks
   logic wo_read;
   assign wo_read = (kind == SRC_READ) &&
      (hit(bus_addr, OFS_OWN_SET) || hit(bus_addr, OFS_OWN_CLR) ||
       hit(bus_addr, OFS_DIR_SET) || hit(bus_addr, OFS_DIR_CLR) ||
       hit(bus_addr, OFS_DAT_SET) || hit(bus_addr, OFS_DAT_CLR));

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wo_read |=> (bus_rdata == '0)) else $error("write-only read not zero"); // R10
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != SRC_READ) |=> $stable(bus_rdata)) else $error("rdata moved without read"); // R10
   AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd3) && (SYNC_STAGES == 2)) |-> (pin_q == $past(pad_in, 2))) else $error("sync latency wrong"); // R9
   AST_IDLE_PADS_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd1) && $past(kind == SRC_NONE)) |-> (dir_q == '0)) else $error("direction not reset"); // R1

endmodule

// File: tb/sim_pio_mux_ctrl.sv
module sim_pio_mux_ctrl;

   localparam int N = 8;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_vld = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [N-1:0] bus_wdata = '0, bus_rdata;
   logic [N-1:0] per_out = '0, per_oe = '0, per_in;
   logic [N-1:0] pad_in = '0, pad_out, pad_oe;

   always #2 clk = ~clk;

   pio_mux_ctrl #(.NPIN(N), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .per_out(per_out), .per_oe(per_oe), .per_in(per_in),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

   int n_cmp = 0;
   int n_bad = 0;

   logic [N-1:0] exp_q[$];
   string        tag_q[$];

   logic [N-1:0] m_own = '1, m_dir = '0, m_dat = '0;

   task automatic compare(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input int ofs, input logic [N-1:0] d);
      @(negedge clk);
      bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = AW'(ofs); bus_wdata = d;
      @(negedge clk);
      bus_vld = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      case (ofs)
         0: m_own = m_own | d;
         1: m_own = m_own & ~d;
         3: m_dir = m_dir | d;
         4: m_dir = m_dir & ~d;
         6: m_dat = m_dat | d;
         7: m_dat = m_dat & ~d;
         default: ;
      endcase
   endtask

   task automatic bus_read(input int ofs, input logic [N-1:0] exp, input string tag);
      @(negedge clk);
      bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = AW'(ofs);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_vld = 1'b0;
   endtask

   task automatic check_pads(input string tag);
      @(negedge clk);
      compare(pad_oe,  (m_own & m_dir) | (~m_own & per_oe),  {tag, " pad_oe"});
      compare(pad_out, (m_own & m_dat) | (~m_own & per_out), {tag, " pad_out"});
   endtask

   // monitor
   logic rd_seen = 1'b0;
   always @(posedge clk) rd_seen <= bus_vld && !bus_wr;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            compare(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      join_none

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      compare(pad_oe, 8'h00, "R1 pad_oe after reset");
      bus_read(2, 8'hFF, "R1 ownership after reset");
      bus_read(5, 8'h00, "R1 direction after reset");
      bus_read(8, 8'h00, "R1 data after reset");

      per_out = 8'hAA; per_oe = 8'hF0;

      // R5 / R8 / R6
      bus_write(3, 8'h0F);
      bus_read(5, 8'h0F, "R5 direction set");
      bus_write(6, 8'h05);
      bus_read(8, 8'h05, "R8 data set");
      check_pads("R6 controller-owned");

      // R3 / R7
      bus_write(1, 8'h3C);
      bus_read(2, 8'hC3, "R3 ownership clear");
      check_pads("R7 mixed ownership");

      // R2 partial set
      bus_write(0, 8'h04);
      bus_read(2, 8'hC7, "R2 ownership set keeps zero bits");
      check_pads("R2 line back to controller");

      // R5 clear, R8 clear
      bus_write(4, 8'h01);
      bus_read(5, 8'h0E, "R5 direction clear");
      bus_write(7, 8'h04);
      bus_read(8, 8'h01, "R8 data clear");

      // R7 direction on peripheral line has no effect
      bus_write(3, 8'h10);
      check_pads("R7 direction on peripheral line");
      per_oe = 8'h00; per_out = 8'h55;
      check_pads("R7 peripheral enable change");
      bus_write(0, 8'h10);
      check_pads("R7 stored direction takes over");

      // R4 write to status ignored
      bus_write(2, 8'h00);
      bus_read(2, 8'hD7, "R4 status write ignored");

      // R10 write-only offsets read zero
      bus_read(0, 8'h00, "R10 read offset 0");
      bus_read(1, 8'h00, "R10 read offset 1");
      bus_read(3, 8'h00, "R10 read offset 3");
      bus_read(4, 8'h00, "R10 read offset 4");
      bus_read(6, 8'h00, "R10 read offset 6");
      bus_read(7, 8'h00, "R10 read offset 7");
      bus_read(12, 8'h00, "R10 unused offset");

      // R9 input path
      @(negedge clk);
      pad_in = 8'h5A;
      #0;
      compare(per_in, 8'h5A, "R9 per_in passthrough");
      @(negedge clk);
      @(negedge clk);
      bus_read(9, 8'h5A, "R9 synced pin read");
      pad_in = 8'h3C;
      repeat (2) @(negedge clk);
      bus_read(9, 8'h3C, "R9 synced pin read second");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R10 missing read data actual=%0d expected=0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule